// File: doc/BRIEF.md
# Peripheral Interrupt Vector Expander

This block gathers seven peripheral interrupt requests onto two shared core interrupt lines. Each source has a pending latch, set by a one-cycle request pulse, and an enable bit. A core line is high while any enabled, pending source in its group is present.

When the core's handler reads the shared system vector register, the block returns a sparse offset code. The code names the enabled pending source with the highest fixed priority. The same read clears that source's pending latch, so the handler can read again to find the next source. A read made while no enabled source is pending returns zero and has no effect.

Top module: `irq_vector_expander`

## Requirements
- R1: After reset all pending latches are clear, both core lines are low and the vector data reads 0000h.
- R2: A one-cycle pulse on reqPulse[i] sets the pending latch of source i at that clock edge. When that source is enabled, its group line is high from that edge onward.
- R3: A source whose srcEnable bit is low still latches its request but drives neither a line nor the vector data. Raising its enable later makes it visible without a new request.
- R4: Sources 0 to 2 (SPI low, SCI receive, SCI transmit) drive coreIrq[0]. Sources 3 to 6 (ADC, external 1, 2 and 3) drive coreIrq[1].
- R5: The vector data reports the enabled pending source with the lowest index, so source 0 has the highest priority and source 6 the lowest.
- R6: The offset codes for sources 0 to 6 are 0005h, 0006h, 0007h, 0004h, 0001h, 0011h and 001Fh.
- R7: A cycle with vecRead high clears, at its closing edge, only the latch of the source that the vector data names during that cycle.
- R8: A read while no enabled source is pending returns 0000h and clears no latch, including the latches of disabled sources.
- R9: A request pulse for a source in the same cycle as a read that clears that source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqPulse | input | 7 | Per-source request pulses, bit i is source i |
| srcEnable | input | 7 | Per-source enables |
| vecRead | input | 1 | Read strobe of the system vector register |
| coreIrq | output | 2 | Shared core interrupt lines, bit 0 for sources 0 to 2, bit 1 for sources 3 to 6 |
| vecData | output | 16 | Offset code of the winning source, 0000h when none |

## Verification
A latch that fails to set or clear shows up on the vector data and on its group line one edge after the pulse or read. It also changes every later read in the same sequence. A wrong priority order or offset table shows as a wrong code on the very first read of a multi-source burst. A latch that a mistaken read cleared, or a request that a clear swallowed, stays hidden until its source is enabled or read again. The directed scenarios therefore always read or enable once more to reveal that state.

// File: rtl/ivx_pkg.sv
`timescale 1ns/1ps
package ivx_pkg;
  localparam int NUM_SRC   = 7;
  localparam int NUM_LINES = 2;
  localparam int VEC_W     = 16;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int SPLIT_AT  = 3;  // first source of the second line group

  typedef struct packed {
    logic [NUM_SRC-1:0] clrMask;
    logic [IDX_W-1:0]   winIdx;
    logic               winValid;
  } ivxStrobe_t;

  function automatic logic [VEC_W-1:0] srcOffset(input int idx);
    case (idx)
      0:       return VEC_W'(16'h0005);
      1:       return VEC_W'(16'h0006);
      2:       return VEC_W'(16'h0007);
      3:       return VEC_W'(16'h0004);
      4:       return VEC_W'(16'h0001);
      5:       return VEC_W'(16'h0011);
      6:       return VEC_W'(16'h001F);
      default: return '0;
    endcase
  endfunction

  function automatic logic [NUM_SRC-1:0] groupMask(input int line);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if ((line == 0) == (s < SPLIT_AT)) m[s] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ivx_control.sv
`timescale 1ns/1ps
module ivx_control
  import ivx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] maskedPend,
  input  logic               vecRead,
  output ivxStrobe_t         strobe
);
  logic [IDX_W-1:0] winIdx;
  logic             winValid;

  always_comb begin
    winIdx   = '0;
    winValid = 1'b0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (maskedPend[s]) begin
        winIdx   = IDX_W'(s);
        winValid = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.winIdx   = winIdx;
    strobe.winValid = winValid;
    strobe.clrMask  = '0;
    if (vecRead && winValid) strobe.clrMask[winIdx] = 1'b1;
  end

  // R7: a read clears at most one source
  a_r7_single_clear: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.clrMask));
  // R8: idle read clears nothing
  a_r8_idle_read: assert property (@(posedge clk) disable iff (!rstN)
    (vecRead && maskedPend == '0) |-> (strobe.clrMask == '0));
  // R5: the cleared source is pending and enabled
  a_r5_clear_is_pending: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.clrMask & ~maskedPend) == '0));
endmodule

// File: rtl/ivx_datapath.sv
`timescale 1ns/1ps
module ivx_datapath
  import ivx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   reqPulse,
  input  logic [NUM_SRC-1:0]   srcEnable,
  input  ivxStrobe_t           strobe,
  output logic [NUM_SRC-1:0]   maskedPend,
  output logic [NUM_LINES-1:0] coreIrq,
  output logic [VEC_W-1:0]     vecData
);
  logic [NUM_SRC-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else       pend <= (pend & ~strobe.clrMask) | reqPulse;
  end

  assign maskedPend = pend & srcEnable;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
      assign coreIrq[g] = |(maskedPend & groupMask(g));
    end
  endgenerate

  always_comb begin
    vecData = '0;
    if (strobe.winValid) vecData = srcOffset(int'(strobe.winIdx));
  end

  // R9: a fresh request is never lost to a clear
  a_r9_request_wins: assert property (@(posedge clk) disable iff (!rstN)
    (reqPulse != '0) |=> ((pend & $past(reqPulse)) == $past(reqPulse)));
  // R7: the reported source is gone after the read
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrMask != '0) |=> ((pend & $past(strobe.clrMask & ~reqPulse)) == '0));
  // R2: pending latch is only set by a request
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN)
    ((pend & ~$past(pend) & ~$past(reqPulse)) == '0));
endmodule

// File: rtl/irq_vector_expander.sv
`timescale 1ns/1ps
module irq_vector_expander
  import ivx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   reqPulse,
  input  logic [NUM_SRC-1:0]   srcEnable,
  input  logic                 vecRead,
  output logic [NUM_LINES-1:0] coreIrq,
  output logic [VEC_W-1:0]     vecData
);
  ivxStrobe_t         strobe;
  logic [NUM_SRC-1:0] maskedPend;

  ivx_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .maskedPend (maskedPend),
    .vecRead    (vecRead),
    .strobe     (strobe)
  );

  ivx_datapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .reqPulse   (reqPulse),
    .srcEnable  (srcEnable),
    .strobe     (strobe),
    .maskedPend (maskedPend),
    .coreIrq    (coreIrq),
    .vecData    (vecData)
  );

  // R4: any raised line implies a nonzero vector
  a_r4_line_has_vector: assert property (@(posedge clk) disable iff (!rstN)
    (coreIrq != '0) |-> (vecData != '0));
  // R1: reset leaves the lines low
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rstN) |-> (coreIrq == '0));
endmodule

// File: tb/test_irq_vector_expander.sv
`timescale 1ns/1ps
module test_irq_vector_expander;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  reqPulse = '0;
  logic [6:0]  srcEnable = '0;
  logic        vecRead = 1'b0;
  logic [1:0]  coreIrq;
  logic [15:0] vecData;
  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  localparam logic [15:0] EXP_CODE [7] = '{16'h0005, 16'h0006, 16'h0007,
                                          16'h0004, 16'h0001, 16'h0011, 16'h001F};

  always #2.5 clk = ~clk;

  irq_vector_expander i_irq_vector_expander (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .srcEnable(srcEnable),
    .vecRead(vecRead), .coreIrq(coreIrq), .vecData(vecData)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [6:0] m);
    reqPulse = m;
    step();
    reqPulse = '0;
  endtask

  task automatic drain();
    srcEnable = '1;
    vecRead = 1'b1;
    repeat (8) step();
    vecRead = 1'b0;
  endtask

  task automatic tReset();
    step();
    check("R1 lines", 16'(coreIrq), 16'h0);
    check("R1 vector", vecData, 16'h0);
    rstN = 1'b1;
    step();
    check("R1 after release", vecData, 16'h0);
  endtask

  task automatic tSingle();
    srcEnable = '1;
    pulse(7'b0001000);
    check("R2 line after pulse", 16'(coreIrq), 16'h2);
    check("R6 adc code", vecData, 16'h0004);
    vecRead = 1'b1;
    step();
    vecRead = 1'b0;
    check("R7 cleared vector", vecData, 16'h0);
    check("R7 cleared line", 16'(coreIrq), 16'h0);
  endtask

  task automatic tOffsets();
    srcEnable = '1;
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      check($sformatf("R6 code src%0d", i), vecData, EXP_CODE[i]);
      check($sformatf("R4 line src%0d", i), 16'(coreIrq), (i < 3) ? 16'h1 : 16'h2);
      vecRead = 1'b1;
      step();
      vecRead = 1'b0;
    end
  endtask

  task automatic tPriority();
    srcEnable = '1;
    pulse(7'h7F);
    check("R4 both lines", 16'(coreIrq), 16'h3);
    vecRead = 1'b1;
    for (int i = 0; i < 7; i++) begin
      check($sformatf("R5 order %0d", i), vecData, EXP_CODE[i]);
      step();
    end
    vecRead = 1'b0;
    check("R7 all drained", vecData, 16'h0);
  endtask

  task automatic tMask();
    srcEnable = 7'b1111110;
    pulse(7'b0000001);
    check("R3 disabled line", 16'(coreIrq), 16'h0);
    check("R3 disabled vector", vecData, 16'h0);
    pulse(7'b0000010);
    check("R3 masked higher skipped", vecData, 16'h0006);
    vecRead = 1'b1;
    step();
    vecRead = 1'b0;
    check("R3 disabled kept", vecData, 16'h0);
    srcEnable = '1;
    #1;
    check("R3 enable reveals", vecData, 16'h0005);
    check("R3 enable line", 16'(coreIrq), 16'h1);
    drain();
  endtask

  task automatic tIdleRead();
    srcEnable = 7'b0111111;
    pulse(7'b1000000);
    vecRead = 1'b1;
    #1;
    check("R8 idle read value", vecData, 16'h0);
    step();
    vecRead = 1'b0;
    srcEnable = '1;
    #1;
    check("R8 nothing cleared", vecData, 16'h001F);
    drain();
  endtask

  task automatic tCollide();
    srcEnable = '1;
    pulse(7'b0000100);
    check("R9 before", vecData, 16'h0007);
    vecRead = 1'b1;
    reqPulse = 7'b0000100;
    step();
    vecRead = 1'b0;
    reqPulse = '0;
    check("R9 still pending", vecData, 16'h0007);
    vecRead = 1'b1;
    step();
    vecRead = 1'b0;
    check("R9 then cleared", vecData, 16'h0);
  endtask

  initial begin
    tReset();
    tSingle();
    tOffsets();
    tPriority();
    tMask();
    tIdleRead();
    tCollide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule